// File: doc/BRIEF.md
# Limit-Compare Interrupt Status Controller

This block sits behind a monitoring sequencer that delivers one measurement at a time, tagged with a channel number. Each measurement is compared against the high and low limits programmed for its channel. The result is written into a per-channel status bit: 1 means out of limit, 0 means in limit. The same bit is also written into a mirror register. A management reader clears the status register by reading it. A second reader can poll the mirror, which is never cleared by a read.

Unmasked status bits are ORed with five external level-sensitive interrupt requests into one pending signal. A small state machine turns that signal into the active-low `int_n` pin. The machine has four states:
- `IRQ_OFF`: the enable bit is 0.
- `IRQ_HUSH`: the clear bit is 1.
- `IRQ_QUIET`: enabled, nothing pending.
- `IRQ_ALERT`: enabled and pending; this is the only state that drives the pin low.

The machine re-evaluates its state from any state on every clock, with this priority:
- enable = 0 goes to `IRQ_OFF`;
- otherwise clear = 1 goes to `IRQ_HUSH`;
- otherwise pending goes to `IRQ_ALERT`;
- otherwise it goes to `IRQ_QUIET`.

Register map, with the default of 8 channels:

| Address | Register |
|---|---|
| 0x00–0x07 | high limits |
| 0x08–0x0F | low limits |
| 0x10 | status (clears when read) |
| 0x11 | mask |
| 0x12 | mirror (read only) |
| 0x13 | config |
| 0x14 | channel mode |
| 0x15 | config 2 |

Top module: `limit_irq_ctrl`

## Requirements
- R1: A measurement with `meas_valid`=1 writes status bit `meas_ch` at that clock edge: 1 when the signed 8-bit value is greater than the channel's high limit or less than or equal to its low limit, else 0.
- R2: A mask bit (register 0x11, bit n for channel n) of 1 removes status bit n from the interrupt. A mask bit of 0 lets it through.
- R3: `int_n` goes low one clock after the pending signal is 1, provided config bit 1 (enable) is 1 and config bit 3 (clear) is 0. In every other case it is high.
- R4: Setting config bit 3 drives `int_n` high without changing status. Clearing bit 3 again brings the interrupt back while the status bits remain set.
- R5: A read of register 0x10 returns the status value held before the read edge and zeroes every status bit at that edge.
- R6: If a measurement update and a status read fall on the same edge, the updated channel takes the new compare result. All other bits clear.
- R7: Every status update also writes the mirror (register 0x12). Reading the mirror or the status register leaves the mirror unchanged, and mirror bits never affect `int_n`.
- R8: Channel mode bit 7 turns on the external inputs. Inputs 0–2 request when low, and inputs 3–4 request when high. Input n is enabled by channel mode bit 4+n for n=0..2 and by config 2 bit 6+(n-3) for n=3..4. The requests are not latched and follow the pin level.
- R9: After reset, status, mirror, mask and config are 0, `int_n` is high, high limits are 0x7F and low limits are 0x80.
- R10: Written registers read back their written value. Read data appears on `reg_rdata` one clock after the `reg_rd` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | Measurement strobe |
| meas_ch | input | 3 | Channel index of the measurement |
| meas_val | input | 8 | Signed measurement value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ext_irq_in | input | 5 | External level interrupt pins |
| int_n | output | 1 | Active-low interrupt output |

## Verification
The hardest case to reach is a measurement update that lands on the same edge as a status read. The bench drives `meas_valid` and `reg_rd` in the same half-cycle, with a different channel already set, and then checks three things: the returned old value, the surviving new bit, and the cleared old bit. Signed limit boundaries are covered by table vectors that sit exactly on each limit and one step beyond it. One vector is chosen so that an unsigned compare would disagree with the signed one.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int EXT_N = 5;
    localparam logic [EXT_N-1:0] EXT_ACT_HIGH = 5'b11000;
    localparam int CFG_EN_BIT   = 1;
    localparam int CFG_CLR_BIT  = 3;
    localparam int MODE_EXT_BIT = 7;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_QUIET = 2'd1,
        IRQ_ALERT = 2'd2,
        IRQ_HUSH  = 2'd3
    } irq_state_e;
endpackage

// File: rtl/lic_limit_cmp.sv
module lic_limit_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    output logic              out_o
);
    always_comb begin
        out_o = ($signed(value_i) > $signed(hi_i)) || ($signed(value_i) <= $signed(lo_i));
    end
endmodule

// File: rtl/lic_status_bank.sv
module lic_status_bank #(
    parameter int NUM_CH = 8,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [CH_W-1:0]   upd_ch,
    input  logic              upd_bit,
    input  logic              rd_clear,
    output logic [NUM_CH-1:0] status_o,
    output logic [NUM_CH-1:0] mirror_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
            mirror_o <= '0;
        end else begin
            if (rd_clear) begin
                status_o <= '0;
            end
            if (upd_valid) begin
                status_o[upd_ch] <= upd_bit;
                mirror_o[upd_ch] <= upd_bit;
            end
        end
    end

    // R5: a read with no update leaves the status empty
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !upd_valid) |=> (status_o == '0));

    // R6: an update on the read edge survives the clear
    a_r6_update_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && rd_clear) |=> (status_o[$past(upd_ch)] == $past(upd_bit)));

    // R7: mirror follows each update
    a_r7_mirror_follows: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (mirror_o[$past(upd_ch)] == $past(upd_bit)));

    // R7: a read never disturbs the mirror
    a_r7_mirror_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !upd_valid) |=> (mirror_o == $past(mirror_o)));
endmodule

// File: rtl/lic_ext_irq.sv
module lic_ext_irq
    import lic_pkg::*;
(
    input  logic             mode_i,
    input  logic [EXT_N-1:0] en_i,
    input  logic [EXT_N-1:0] pin_i,
    output logic [EXT_N-1:0] req_o
);
    for (genvar g = 0; g < EXT_N; g++) begin : g_pin
        if (EXT_ACT_HIGH[g]) begin : g_hi
            assign req_o[g] = mode_i & en_i[g] & pin_i[g];
        end else begin : g_lo
            assign req_o[g] = mode_i & en_i[g] & ~pin_i[g];
        end
    end
endmodule

// File: rtl/lic_irq_fsm.sv
module lic_irq_fsm
    import lic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic pending_i,
    output logic int_n_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_OFF, IRQ_QUIET, IRQ_ALERT, IRQ_HUSH: begin
                if (!en_i)          state_d = IRQ_OFF;
                else if (clr_i)     state_d = IRQ_HUSH;
                else if (pending_i) state_d = IRQ_ALERT;
                else                state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_ALERT: int_n_o = 1'b0;
            IRQ_OFF, IRQ_QUIET, IRQ_HUSH: int_n_o = 1'b1;
            default: int_n_o = 1'b1;
        endcase
    end

    // R3: disabled output stays high
    a_r3_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> int_n_o);

    // R3: enabled, unsilenced and pending drives the pin low
    a_r3_alert_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && pending_i) |=> !int_n_o);

    // R4: the clear bit silences the pin
    a_r4_hush_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_i) |=> int_n_o);
endmodule

// File: rtl/limit_irq_ctrl.sv
module limit_irq_ctrl
    import lic_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic [CH_W-1:0]   meas_ch,
    input  logic [DATA_W-1:0] meas_val,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EXT_N-1:0]  ext_irq_in,
    output logic              int_n
);
    localparam int A_HI     = 0;
    localparam int A_LO     = NUM_CH;
    localparam int A_STATUS = 2 * NUM_CH;
    localparam int A_MASK   = A_STATUS + 1;
    localparam int A_MIRROR = A_STATUS + 2;
    localparam int A_CFG    = A_STATUS + 3;
    localparam int A_MODE   = A_STATUS + 4;
    localparam int A_CFG2   = A_STATUS + 5;
    localparam logic [DATA_W-1:0] HI_RST = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] LO_RST = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] lim_hi [NUM_CH];
    logic [DATA_W-1:0] lim_lo [NUM_CH];
    logic [DATA_W-1:0] mask_q, cfg_q, mode_q, cfg2_q, rd_mux;
    logic [NUM_CH-1:0] cmp_out, status, mirror;
    logic [EXT_N-1:0]  ext_req, ext_en;
    logic upd_valid, rd_clear, pending;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        lic_limit_cmp #(.DATA_W(DATA_W)) u_cmp (
            .value_i(meas_val), .hi_i(lim_hi[g]), .lo_i(lim_lo[g]), .out_o(cmp_out[g])
        );
    end

    assign upd_valid = meas_valid && ({1'b0, meas_ch} < (CH_W+1)'(NUM_CH));
    assign rd_clear  = reg_rd && (reg_addr == ADDR_W'(A_STATUS));

    lic_status_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ch(meas_ch),
        .upd_bit(cmp_out[meas_ch]), .rd_clear(rd_clear),
        .status_o(status), .mirror_o(mirror)
    );

    assign ext_en = {cfg2_q[7:6], mode_q[6:4]};

    lic_ext_irq u_ext (
        .mode_i(mode_q[MODE_EXT_BIT]), .en_i(ext_en), .pin_i(ext_irq_in), .req_o(ext_req)
    );

    assign pending = (|(status & ~mask_q[NUM_CH-1:0])) | (|ext_req);

    lic_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(cfg_q[CFG_EN_BIT]), .clr_i(cfg_q[CFG_CLR_BIT]),
        .pending_i(pending), .int_n_o(int_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                lim_hi[i] <= HI_RST;
                lim_lo[i] <= LO_RST;
            end
            mask_q <= '0;
            cfg_q  <= '0;
            mode_q <= '0;
            cfg2_q <= '0;
        end else if (reg_wr) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (reg_addr == ADDR_W'(A_HI + i)) lim_hi[i] <= reg_wdata;
                if (reg_addr == ADDR_W'(A_LO + i)) lim_lo[i] <= reg_wdata;
            end
            if (reg_addr == ADDR_W'(A_MASK)) mask_q <= reg_wdata;
            if (reg_addr == ADDR_W'(A_CFG))  cfg_q  <= reg_wdata;
            if (reg_addr == ADDR_W'(A_MODE)) mode_q <= reg_wdata;
            if (reg_addr == ADDR_W'(A_CFG2)) cfg2_q <= reg_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(A_HI + i)) rd_mux = lim_hi[i];
            if (reg_addr == ADDR_W'(A_LO + i)) rd_mux = lim_lo[i];
        end
        if (reg_addr == ADDR_W'(A_STATUS)) rd_mux = DATA_W'(status);
        if (reg_addr == ADDR_W'(A_MASK))   rd_mux = mask_q;
        if (reg_addr == ADDR_W'(A_MIRROR)) rd_mux = DATA_W'(mirror);
        if (reg_addr == ADDR_W'(A_CFG))    rd_mux = cfg_q;
        if (reg_addr == ADDR_W'(A_MODE))   rd_mux = mode_q;
        if (reg_addr == ADDR_W'(A_CFG2))   rd_mux = cfg2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R9: output is high in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> int_n);
endmodule

// File: tb/tb_limit_irq_ctrl.sv
`timescale 1ns/1ps
module tb_limit_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic meas_valid = 1'b0;
    logic [2:0] meas_ch = '0;
    logic [7:0] meas_val = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] ext_irq_in = 5'b00111;
    logic int_n;
    int checks = 0, errors = 0;
    logic [7:0] mir_model = '0;
    logic [7:0] rv;

    localparam logic [5:0] A_STATUS = 6'd16, A_MASK = 6'd17, A_MIRROR = 6'd18,
                           A_CFG = 6'd19, A_MODE = 6'd20, A_CFG2 = 6'd21;

    // {value, high, low, expected out-of-limit}
    localparam logic [31:0] VEC [10] = '{
        32'h0A_14_05_00, 32'h15_14_05_01, 32'h14_14_05_00, 32'h05_14_05_01,
        32'h06_14_05_00, 32'hFD_0A_FC_00, 32'hFC_0A_FC_01, 32'h80_7F_80_01,
        32'h7F_7F_80_00, 32'h81_00_80_00
    };

    always #2.5 clk = ~clk;

    limit_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ch(meas_ch),
        .meas_val(meas_val), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq_in(ext_irq_in), .int_n(int_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic meas(input logic [2:0] ch, input logic [7:0] v);
        meas_valid = 1'b1; meas_ch = ch; meas_val = v;
        tick();
        meas_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        chk("R9 int_n", {7'd0, int_n}, 8'h01);
        rd(A_STATUS, rv); chk("R9 status", rv, 8'h00);
        rd(A_MIRROR, rv); chk("R9 mirror", rv, 8'h00);
        rd(A_MASK, rv);   chk("R9 mask", rv, 8'h00);
        rd(A_CFG, rv);    chk("R9 config", rv, 8'h00);
        rd(6'd0, rv);     chk("R9 high limit", rv, 8'h7F);
        rd(6'd8, rv);     chk("R9 low limit", rv, 8'h80);

        // R1 table of compare vectors, R5 and R7 on each
        for (int i = 0; i < 10; i++) begin
            logic [2:0] ch;
            ch = 3'(i % 8);
            wr(6'(ch), VEC[i][23:16]);
            wr(6'(8 + ch), VEC[i][15:8]);
            meas(ch, VEC[i][31:24]);
            mir_model[ch] = VEC[i][0];
            rd(A_MIRROR, rv); chk("R7 mirror", rv, mir_model);
            rd(A_STATUS, rv); chk("R1 status bit", rv, 8'(VEC[i][0]) << ch);
            rd(A_STATUS, rv); chk("R5 cleared by read", rv, 8'h00);
        end

        // R10 readback
        wr(A_MODE, 8'h5A); rd(A_MODE, rv); chk("R10 mode readback", rv, 8'h5A);
        wr(A_MODE, 8'h00);

        // R3 enable gating
        wr(6'd0, 8'h00); wr(6'd8, 8'h80);
        meas(3'd0, 8'h05);
        tick(); chk("R3 disabled high", {7'd0, int_n}, 8'h01);
        wr(A_CFG, 8'h02); tick();
        chk("R3 enabled low", {7'd0, int_n}, 8'h00);
        // R2 mask
        wr(A_MASK, 8'h01); tick(); chk("R2 masked high", {7'd0, int_n}, 8'h01);
        wr(A_MASK, 8'h00); tick(); chk("R2 unmasked low", {7'd0, int_n}, 8'h00);
        // R4 clear bit
        wr(A_CFG, 8'h0A); tick(); chk("R4 clear high", {7'd0, int_n}, 8'h01);
        wr(A_CFG, 8'h02); tick(); chk("R4 status kept", {7'd0, int_n}, 8'h00);
        rd(A_STATUS, rv); chk("R4 status value", rv, 8'h01);
        tick(); chk("R7 mirror no interrupt", {7'd0, int_n}, 8'h01);
        rd(A_MIRROR, rv); chk("R7 mirror kept", rv[0 +: 1] == 1'b1 ? 8'h01 : 8'h00, 8'h01);

        // R6 collision of update and read
        wr(6'd1, 8'h00); wr(6'd9, 8'h80); wr(6'd2, 8'h00); wr(6'd10, 8'h80);
        meas(3'd1, 8'h10);
        meas_valid = 1'b1; meas_ch = 3'd2; meas_val = 8'h10;
        reg_rd = 1'b1; reg_addr = A_STATUS;
        tick();
        meas_valid = 1'b0; reg_rd = 1'b0;
        chk("R6 read old", reg_rdata, 8'h02);
        rd(A_STATUS, rv); chk("R6 update wins", rv, 8'h04);

        // R8 external level inputs
        tick(); chk("R8 idle high", {7'd0, int_n}, 8'h01);
        wr(A_MODE, 8'hF0); wr(A_CFG2, 8'hC0);
        ext_irq_in = 5'b00110; tick(); tick();
        chk("R8 pin0 low requests", {7'd0, int_n}, 8'h00);
        ext_irq_in = 5'b00111; tick(); tick();
        chk("R8 not latched", {7'd0, int_n}, 8'h01);
        ext_irq_in = 5'b01111; tick(); tick();
        chk("R8 pin3 high requests", {7'd0, int_n}, 8'h00);
        wr(A_CFG2, 8'h80); tick();
        chk("R8 pin3 disabled", {7'd0, int_n}, 8'h01);
        ext_irq_in = 5'b00110; wr(A_MODE, 8'h70); tick();
        chk("R8 mode off", {7'd0, int_n}, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule